// File: doc/BRIEF.md
# Scan Chunk Sample Decimator

This block sits on the sample stream behind an acquisition FIFO. The converter runs from one fast conversion clock, and a slower scan rate comes from throwing conversions away. Consecutive samples form chunks of N×(1+D) conversions. N is the number of channels in one scan. D is the number of idle scan slots that follow each real scan. Only the leading N samples of each chunk go on downstream. The remaining N×D samples are consumed and dropped. D is chosen as the scan period divided by (N × conversion period), minus one, so the scan period must be a whole multiple of N conversion periods.

Each forwarded sample is rewritten from the converter's two's-complement word into unsigned offset form. A 16-bit mode and a 12-bit mode are available. The block also counts completed scans. When a stop count is armed, it raises end-of-acquisition after the chosen number of scans and then halts both streams. The chunk phase carries over gaps in the input stream, so bursts of any size may arrive. A start pulse latches the configuration and clears all progress.

Top module: `scan_decim`

## Requirements
- R1: After reset and before the first start pulse, `in_ready`, `out_valid` and `eoa` are all 0, even while `in_valid` is 1.
- R2: A start pulse latches N, D, the mode and the stop settings, clears the chunk phase and the scan count, and clears `eoa`. Changes on the configuration inputs between start pulses have no effect.
- R3: Number the accepted samples k = 0, 1, 2, ... from the last start. Sample k is forwarded when (k mod N×(1+D)) < N and is discarded otherwise.
- R4: With D = 0, every accepted sample is forwarded, in arrival order.
- R5: A sample that will be discarded is accepted (`in_ready` = 1) whatever the value of `out_ready`, and it drives `out_valid` = 0. A sample that will be kept is presented on `out_valid` with `in_ready` equal to `out_ready`, and it stays stable until it is taken.
- R6: Cycles with `in_valid` = 0 do not move the chunk phase. The pattern continues exactly across gaps.
- R7: When `cfg_mode` = 0 (16-bit mode), `out_data` = `in_data` XOR 0x8000.
- R8: When `cfg_mode` = 1 (12-bit mode), `out_data` = {4'b0000, `in_data`[15:4] XOR 0x800}.
- R9: When the stop count is enabled, `eoa` rises in the cycle after the handshake of the last sample of scan number `cfg_stop_cnt`. From then until the next start, `in_ready` and `out_valid` stay 0.
- R10: An enabled stop count of 0 is treated as 1.
- R11: With `cfg_stop_en` = 0, `eoa` never rises, whatever the value of `cfg_stop_cnt`.
- R12: An N of 0 is latched as 1, and an N above MAX_CH is latched as MAX_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: latch configuration, clear progress |
| cfg_nchan | input | CH_W (5) | Channels per scan, N |
| cfg_idle | input | IDLE_W (8) | Idle scan slots per chunk, D |
| cfg_mode | input | 1 | 0: 16-bit offset conversion, 1: 12-bit conversion |
| cfg_stop_en | input | 1 | Arm the scan stop count |
| cfg_stop_cnt | input | STOP_W (16) | Number of scans before end-of-acquisition |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W (16) | Raw converter word |
| in_ready | output | 1 | Input sample accepted this cycle when high with in_valid |
| out_valid | output | 1 | Forwarded sample valid |
| out_data | output | DATA_W (16) | Converted sample |
| out_ready | input | 1 | Downstream accepts the sample |
| eoa | output | 1 | End of acquisition, held until the next start |

## Verification
The bench goes after the chunk wrap. A counter that wraps one sample early or late forwards a sample from the idle region or drops the first sample of the next scan, and this shows up within the first two chunks of an N=3, D=2 stream. Gaps in the input and a restart in mid-chunk target a phase that follows the clock rather than accepted samples, or that survives a start. Back-pressure on a kept sample and on a discarded sample separates a design that stalls on dropped data from one that lets a held sample change or slip through. The stop tests count to the exact scan: an off-by-one counter raises `eoa` a scan early or late, a zero stop count either never ends or ends at once, and a disabled count must never end the run.

// File: rtl/scan_decim_pkg.sv
package scan_decim_pkg;

   // Output conversion applied to every forwarded sample
   typedef enum logic {
      FMT_WIDE   = 1'b0,   // full-width word, sign bit inverted
      FMT_NARROW = 1'b1    // top NARROW_W bits, right aligned, sign bit inverted
   } fmt_mode_e;

endpackage

// File: rtl/sample_fmt.sv
module sample_fmt
   import scan_decim_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NARROW_W  = 12,
   parameter bit NARROW_EN = 1'b1
) (
   input  fmt_mode_e           mode,
   input  logic [DATA_W-1:0]   raw,
   output logic [DATA_W-1:0]   fmt
);

   localparam int SHIFT = DATA_W - NARROW_W;

   if (DATA_W < 2) begin : g_bad_width
      $error("sample_fmt: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] wide_w;
   assign wide_w = {~raw[DATA_W-1], raw[DATA_W-2:0]};

   if (NARROW_EN) begin : g_narrow
      if (NARROW_W < 2 || NARROW_W >= DATA_W) begin : g_bad_narrow
         $error("sample_fmt: NARROW_W must lie in 2..DATA_W-1");
      end
      logic [DATA_W-1:0] narrow_w;
      assign narrow_w = {{SHIFT{1'b0}}, ~raw[DATA_W-1], raw[DATA_W-2:SHIFT]};
      assign fmt = (mode == FMT_NARROW) ? narrow_w : wide_w;
   end else begin : g_wide_only
      logic unused_mode;
      assign unused_mode = mode;
      assign fmt = wide_w;
   end

endmodule

// File: rtl/scan_phase.sv
module scan_phase #(
   parameter int CH_W   = 5,
   parameter int IDLE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [CH_W-1:0]   nch,
   input  logic [IDLE_W-1:0] idle,
   output logic              keep,
   output logic              scan_last
);

   // Two nested counters: sample slot inside a scan, scan slot inside a chunk.
   logic [CH_W-1:0]   pos_q;
   logic [IDLE_W-1:0] slot_q;
   logic              last_pos;

   assign last_pos  = (pos_q == nch - CH_W'(1));
   assign keep      = (slot_q == '0);
   assign scan_last = keep & last_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q  <= '0;
         slot_q <= '0;
      end else if (clr) begin
         pos_q  <= '0;
         slot_q <= '0;
      end else if (step) begin
         if (last_pos) begin
            pos_q  <= '0;
            slot_q <= (slot_q == idle) ? '0 : slot_q + IDLE_W'(1);
         end else begin
            pos_q  <= pos_q + CH_W'(1);
         end
      end
   end

   assert_pos_in_window_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      pos_q < nch);

   assert_slot_in_chunk_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= idle);

   assert_wrap_reopens_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && last_pos && slot_q == idle) |=> keep);

   assert_hold_without_step_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> ($stable(pos_q) && $stable(slot_q)));

endmodule

// File: rtl/scan_stop.sv
module scan_stop #(
   parameter int STOP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              scan_done,
   input  logic              stop_en,
   input  logic [STOP_W-1:0] stop_cnt,
   output logic              eoa
);

   logic [STOP_W-1:0] scans_q;
   logic              eoa_q;
   logic [STOP_W-1:0] scans_next;

   assign scans_next = scans_q + STOP_W'(1);
   assign eoa        = eoa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scans_q <= '0;
         eoa_q   <= 1'b0;
      end else if (clr) begin
         scans_q <= '0;
         eoa_q   <= 1'b0;
      end else if (scan_done) begin
         scans_q <= scans_next;
         if (stop_en && scans_next >= stop_cnt) eoa_q <= 1'b1;
      end
   end

   assert_eoa_needs_enable_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoa_q) |-> stop_en);

   assert_eoa_follows_scan_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoa_q) |-> $past(scan_done));

endmodule

// File: rtl/scan_decim.sv
module scan_decim
   import scan_decim_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NARROW_W  = 12,
   parameter bit NARROW_EN = 1'b1,
   parameter int MAX_CH    = 16,
   parameter int MAX_IDLE  = 255,
   parameter int STOP_W    = 16,
   localparam int CH_W     = $clog2(MAX_CH + 1),
   localparam int IDLE_W   = $clog2(MAX_IDLE + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CH_W-1:0]   cfg_nchan,
   input  logic [IDLE_W-1:0] cfg_idle,
   input  logic              cfg_mode,
   input  logic              cfg_stop_en,
   input  logic [STOP_W-1:0] cfg_stop_cnt,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   input  logic              out_ready,
   output logic              eoa
);

   if (MAX_CH < 1) begin : g_bad_ch
      $error("scan_decim: MAX_CH must be at least 1");
   end
   if (MAX_IDLE < 1) begin : g_bad_idle
      $error("scan_decim: MAX_IDLE must be at least 1");
   end
   if (STOP_W < 1) begin : g_bad_stop
      $error("scan_decim: STOP_W must be at least 1");
   end

   // ---------------- configuration latch ----------------
   logic              run_q;
   logic [CH_W-1:0]   nch_q;
   logic [IDLE_W-1:0] idle_q;
   fmt_mode_e         mode_q;
   logic              stop_en_q;
   logic [STOP_W-1:0] stop_q;

   logic [CH_W-1:0]   nch_fix;
   logic [IDLE_W-1:0] idle_fix;
   logic [STOP_W-1:0] stop_fix;

   always_comb begin
      if (cfg_nchan == '0)                 nch_fix = CH_W'(1);
      else if (cfg_nchan > CH_W'(MAX_CH))  nch_fix = CH_W'(MAX_CH);
      else                                 nch_fix = cfg_nchan;
      idle_fix = (cfg_idle > IDLE_W'(MAX_IDLE)) ? IDLE_W'(MAX_IDLE) : cfg_idle;
      stop_fix = (cfg_stop_cnt == '0) ? STOP_W'(1) : cfg_stop_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         nch_q     <= CH_W'(1);
         idle_q    <= '0;
         mode_q    <= FMT_WIDE;
         stop_en_q <= 1'b0;
         stop_q    <= STOP_W'(1);
      end else if (start) begin
         run_q     <= 1'b1;
         nch_q     <= nch_fix;
         idle_q    <= idle_fix;
         mode_q    <= fmt_mode_e'(cfg_mode);
         stop_en_q <= cfg_stop_en;
         stop_q    <= stop_fix;
      end
   end

   // ---------------- stream handshake ----------------
   logic keep;
   logic scan_last;
   logic active;
   logic step;
   logic scan_done;
   logic eoa_w;

   assign active    = run_q & ~eoa_w & ~start;
   assign in_ready  = active & (~keep | out_ready);
   assign out_valid = active & in_valid & keep;
   assign step      = in_valid & in_ready;
   assign scan_done = step & scan_last;
   assign eoa       = eoa_w;

   scan_phase #(
      .CH_W   (CH_W),
      .IDLE_W (IDLE_W)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start),
      .step      (step),
      .nch       (nch_q),
      .idle      (idle_q),
      .keep      (keep),
      .scan_last (scan_last)
   );

   scan_stop #(
      .STOP_W (STOP_W)
   ) u_stop (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (start),
      .scan_done (scan_done),
      .stop_en   (stop_en_q),
      .stop_cnt  (stop_q),
      .eoa       (eoa_w)
   );

   sample_fmt #(
      .DATA_W    (DATA_W),
      .NARROW_W  (NARROW_W),
      .NARROW_EN (NARROW_EN)
   ) u_fmt (
      .mode (mode_q),
      .raw  (in_data),
      .fmt  (out_data)
   );

   // ---------------- assertions ----------------
   assert_idle_before_start_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (!in_ready && !out_valid && !eoa));

   assert_held_sample_stable_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

   assert_halt_after_eoa_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      eoa |-> (!in_ready && !out_valid));

   assert_eoa_only_after_start_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !eoa);

   if (NARROW_EN) begin : g_narrow_chk
      assert_narrow_top_zero_R8 : assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && mode_q == FMT_NARROW) |-> (out_data[DATA_W-1:NARROW_W] == '0));
   end

endmodule

// File: tb/scan_decim_bench.sv
`timescale 1ns/1ps
module scan_decim_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  cfg_nchan = '0;
   logic [7:0]  cfg_idle = '0;
   logic        cfg_mode = 1'b0;
   logic        cfg_stop_en = 1'b0;
   logic [15:0] cfg_stop_cnt = '0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [15:0] out_data;
   logic        out_ready = 1'b1;
   logic        eoa;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   // bench-side model state
   int mN = 1;
   int mD = 0;
   int mMode = 0;
   int mIdx = 0;

   always #5 clk = ~clk;

   scan_decim u_scan_decim (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cfg_nchan    (cfg_nchan),
      .cfg_idle     (cfg_idle),
      .cfg_mode     (cfg_mode),
      .cfg_stop_en  (cfg_stop_en),
      .cfg_stop_cnt (cfg_stop_cnt),
      .in_valid     (in_valid),
      .in_data      (in_data),
      .in_ready     (in_ready),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .out_ready    (out_ready),
      .eoa          (eoa)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int k);
      return 16'h1234 + 16'(k * 16'h0713);
   endfunction

   function automatic logic [15:0] conv(input logic [15:0] d);
      if (mMode == 0) return d ^ 16'h8000;
      return {4'h0, d[15:4] ^ 12'h800};
   endfunction

   function automatic bit kept(input int k);
      return (k % (mN * (mD + 1))) < mN;
   endfunction

   task automatic do_start(input int n_in, input int n_eff, input int d, input int mode,
                           input bit sen, input int scnt);
      @(negedge clk);
      cfg_nchan = 5'(n_in); cfg_idle = 8'(d); cfg_mode = mode[0];
      cfg_stop_en = sen; cfg_stop_cnt = 16'(scnt); start = 1'b1; in_valid = 1'b0;
      @(negedge clk);
      start = 1'b0;
      mN = n_eff; mD = d; mMode = mode; mIdx = 0;
   endtask

   // push cnt samples; every third sample is followed by gap idle cycles
   task automatic feed(input int cnt, input int gap, input string tag);
      for (int i = 0; i < cnt; i++) begin
         logic [15:0] d;
         bit k;
         @(negedge clk);
         d = pat(mIdx);
         k = kept(mIdx);
         in_valid = 1'b1; in_data = d; out_ready = 1'b1;
         #1;
         check(out_valid === k, {tag, " keep"}, 32'(out_valid), 32'(k));
         if (k) check(out_data === conv(d), {tag, " data"}, 32'(out_data), 32'(conv(d)));
         check(in_ready === 1'b1, {tag, " ready"}, 32'(in_ready), 32'd1);
         @(posedge clk);
         mIdx++;
         if (gap > 0 && (i % 3) == 2) begin
            #1 in_valid = 1'b0;
            repeat (gap) @(posedge clk);
         end
      end
      #1 in_valid = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      in_valid = 1'b1; in_data = 16'hAAAA;
      #1;
      check(in_ready === 1'b0, "R1 in_ready", 32'(in_ready), 0);
      check(out_valid === 1'b0, "R1 out_valid", 32'(out_valid), 0);
      check(eoa === 1'b0, "R1 eoa", 32'(eoa), 0);
      in_valid = 1'b0;
   endtask

   task automatic t_decim_gaps;
      do_start(3, 3, 2, 0, 1'b0, 0);
      feed(27, 2, "R3 R6 R7");
   endtask

   task automatic t_passthru;
      do_start(4, 4, 0, 0, 1'b0, 0);
      feed(12, 0, "R4");
   endtask

   task automatic t_narrow;
      do_start(2, 2, 1, 1, 1'b0, 0);
      feed(10, 1, "R8");
   endtask

   task automatic t_backpressure;
      logic [15:0] d;
      do_start(2, 2, 1, 0, 1'b0, 0);
      @(negedge clk);
      d = pat(0);
      in_valid = 1'b1; in_data = d; out_ready = 1'b0;
      #1;
      check(out_valid === 1'b1, "R5 held valid", 32'(out_valid), 1);
      check(in_ready === 1'b0, "R5 held stall", 32'(in_ready), 0);
      @(negedge clk);
      #1;
      check(out_data === conv(d), "R5 held data", 32'(out_data), 32'(conv(d)));
      check(in_ready === 1'b0, "R5 still stalled", 32'(in_ready), 0);
      out_ready = 1'b1;
      #1;
      check(in_ready === 1'b1, "R5 release", 32'(in_ready), 1);
      @(posedge clk);
      mIdx = 1;
      feed(1, 0, "R5 second kept");
      @(negedge clk);
      in_valid = 1'b1; in_data = pat(2); out_ready = 1'b0;
      #1;
      check(in_ready === 1'b1, "R5 discard no stall", 32'(in_ready), 1);
      check(out_valid === 1'b0, "R5 discard hidden", 32'(out_valid), 0);
      @(posedge clk);
      mIdx = 3;
      #1 in_valid = 1'b0; out_ready = 1'b1;
      feed(5, 0, "R5 resume");
   endtask

   task automatic t_cfg_restart;
      do_start(3, 3, 1, 0, 1'b0, 0);
      feed(2, 0, "R2 pre");
      @(negedge clk);
      cfg_nchan = 5'd1; cfg_idle = 8'd0; cfg_mode = 1'b1; cfg_stop_en = 1'b1;
      cfg_stop_cnt = 16'd1;
      feed(3, 0, "R2 cfg ignored");
      check(eoa === 1'b0, "R2 stop not taken", 32'(eoa), 0);
      do_start(3, 3, 1, 0, 1'b0, 0);
      feed(7, 0, "R2 phase cleared");
   endtask

   task automatic t_stop;
      do_start(2, 2, 1, 0, 1'b1, 3);
      feed(9, 0, "R9 run");
      @(negedge clk);
      check(eoa === 1'b0, "R9 not yet", 32'(eoa), 0);
      feed(1, 0, "R9 last");
      @(negedge clk);
      check(eoa === 1'b1, "R9 eoa", 32'(eoa), 1);
      in_valid = 1'b1; in_data = pat(10);
      #1;
      check(in_ready === 1'b0, "R9 halted in", 32'(in_ready), 0);
      check(out_valid === 1'b0, "R9 halted out", 32'(out_valid), 0);
      in_valid = 1'b0;
   endtask

   task automatic t_stop_zero;
      do_start(1, 1, 0, 0, 1'b1, 0);
      @(negedge clk);
      check(eoa === 1'b0, "R2 R10 eoa cleared", 32'(eoa), 0);
      feed(1, 0, "R10 first");
      @(negedge clk);
      check(eoa === 1'b1, "R10 eoa after one", 32'(eoa), 1);
   endtask

   task automatic t_no_stop;
      do_start(1, 1, 0, 0, 1'b0, 1);
      feed(6, 0, "R11 run");
      @(negedge clk);
      check(eoa === 1'b0, "R11 no eoa", 32'(eoa), 0);
   endtask

   task automatic t_zero_n;
      do_start(0, 1, 1, 0, 1'b0, 0);
      feed(8, 0, "R12 N zero");
      do_start(31, 16, 0, 1, 1'b0, 0);
      feed(4, 0, "R12 N clamp");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_decim_gaps();
      t_passthru();
      t_narrow();
      t_backpressure();
      t_cfg_restart();
      t_stop();
      t_stop_zero();
      t_no_stop();
      t_zero_n();
      repeat (2) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 20000) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule